// File: doc/BRIEF.md
# Register-Bank Serial Slave

This block is a two-wire serial bus slave in front of a small bank of byte-wide registers. It answers only to one fixed 7-bit device address. A write transfer first sets an internal register pointer and then stores the bytes that follow. A read transfer returns bytes starting at the pointer. The pointer steps forward after every data byte, whether the byte is read or written.

The block samples the bus clock and data lines with a fast system clock. It pulls the data line low through an open-drain output flag and never drives it high. A master can set the pointer and then read back without giving up the bus, by sending a repeated START. It can also read directly from wherever the pointer was left.

On the application side, the block has a direct read port and a write port. These let the logic behind the registers observe and refresh the register contents.

Top module: `i2cRegBankSlave`

## Requirements
- R1: After reset, the SDA pull-down flag is 0, every register holds 00h and the pointer is 0.
- R2: For the address byte A2h (device address 51h, R/W bit 0 as LSB) or A3h (R/W 1), the slave pulls SDA low for the whole high phase of the ninth SCL pulse.
- R3: For any other address byte, the slave does not acknowledge. It then leaves SDA, the registers and the pointer untouched until the next START or STOP.
- R4: In a write transfer, the byte after the address loads the pointer from its low 4 bits. Its upper 4 bits are discarded. The byte is acknowledged.
- R5: Each later byte in a write transfer is stored at the pointer and acknowledged, and the pointer then increments.
- R6: The pointer wraps from 15 to 0, for both reads and writes.
- R7: A read that follows a START directly returns data from the pointer's current value. Bytes go out MSB first, and the pointer increments per byte.
- R8: A repeated START with address A3h after a pointer write switches the slave to transmitting from the newly written pointer.
- R9: When the master acknowledges (SDA low in the ninth slot), the slave sends the next byte. When the master does not acknowledge, the slave releases SDA and stops driving.
- R10: The SDA pull-down flag changes only while the synchronized SCL is low.
- R11: A STOP returns the slave to idle with SDA released.
- R12: The application write port updates a register, and the application read port returns register contents. Bus reads see values written by the application, and the application sees values written over the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaPullLow | output | 1 | 1 = pull SDA low, 0 = release |
| appWrEn | input | 1 | Application register write strobe |
| appWrAddr | input | 4 | Application write register index |
| appWrData | input | 8 | Application write data |
| appRdAddr | input | 4 | Application read register index |
| appRdData | output | 8 | Contents of register appRdAddr |

## Verification
The bench builds the block with its default parameters: 16 registers, device address 51h and a two-stage line synchronizer. With 16 registers, a write starting at pointer 14 and a read starting at pointer 15 both cross the wrap within a few bytes. With the fixed address, the foreign address byte A4h differs from a match only in the address field. The two-stage synchronizer fixes the lag between a bus edge and the SDA response at a few system cycles. The bench's bus timing is set to cover that lag, so acknowledge windows and data bits can be sampled at fixed offsets within each SCL phase.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_RX, ST_TX, ST_TXACK, ST_SKIP
  } busState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic wrReg;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;
endpackage

// File: rtl/i2cLineSync.sv
module i2cLineSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclS     = sclPipe[STAGES-1];
  assign sdaS     = sdaPipe[STAGES-1];
  assign sclRise  = sclS && !sclPrev;
  assign sclFall  = !sclS && sclPrev;
  assign startDet = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopDet  = sclS && sclPrev && !sdaPrev && sdaS;
endmodule

// File: rtl/i2cSlaveCtrl.sv
module i2cSlaveCtrl
  import i2cRegPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h51
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaS,
  input  logic [7:0] rxByte,
  output dpStrobe_t  strobe,
  output logic       ackLow,
  output logic       txActive
);
  busState_t state;
  logic [3:0] bitCnt;
  logic isRead, ptrPhase, mstAck;
  logic rxPhase, byteEnd, addrHit, busEvent;

  assign busEvent = startDet || stopDet;
  assign rxPhase  = (state == ST_ADDR) || (state == ST_RX);
  assign byteEnd  = rxPhase && sclFall && (bitCnt == 4'd8);
  assign addrHit  = (rxByte[7:1] == DEV_ADDR);

  always_comb begin
    strobe.shiftIn = !busEvent && rxPhase && sclRise && (bitCnt < 4'd8);
    strobe.loadPtr = !busEvent && byteEnd && (state == ST_RX) && ptrPhase;
    strobe.wrReg   = !busEvent && byteEnd && (state == ST_RX) && !ptrPhase;
    strobe.loadTx  = !busEvent && sclFall &&
                     (((state == ST_ACK) && isRead) || ((state == ST_TXACK) && mstAck));
    strobe.shiftTx = !busEvent && (state == ST_TX) && sclFall && (bitCnt != 4'd7);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      isRead   <= 1'b0;
      ptrPhase <= 1'b0;
      mstAck   <= 1'b0;
      ackLow   <= 1'b0;
      txActive <= 1'b0;
    end else if (busEvent) begin
      state    <= startDet ? ST_ADDR : ST_IDLE;
      bitCnt   <= '0;
      ackLow   <= 1'b0;
      txActive <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_RX: begin
          if (strobe.shiftIn) bitCnt <= bitCnt + 4'd1;
          if (byteEnd) begin
            bitCnt <= '0;
            if (state == ST_RX) begin
              ptrPhase <= 1'b0;
              ackLow   <= 1'b1;
              state    <= ST_ACK;
            end else if (addrHit) begin
              isRead   <= rxByte[0];
              ptrPhase <= 1'b1;
              ackLow   <= 1'b1;
              state    <= ST_ACK;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_ACK: if (sclFall) begin
          ackLow   <= 1'b0;
          bitCnt   <= '0;
          txActive <= isRead;
          state    <= isRead ? ST_TX : ST_RX;
        end
        ST_TX: if (sclFall) begin
          if (bitCnt == 4'd7) begin
            state    <= ST_TXACK;
            txActive <= 1'b0;
            bitCnt   <= '0;
          end else begin
            bitCnt <= bitCnt + 4'd1;
          end
        end
        ST_TXACK: begin
          if (sclRise) mstAck <= !sdaS;
          if (sclFall) begin
            txActive <= mstAck;
            state    <= mstAck ? ST_TX : ST_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  // R3: a foreign address is never acknowledged
  a_r3_no_ack_foreign: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && byteEnd && !addrHit && !busEvent) |=> (!ackLow && state == ST_SKIP));
  // R9: a master not-acknowledge ends transmission
  a_r9_nack_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TXACK && sclFall && !mstAck && !busEvent) |=> (!txActive && !ackLow));
  // R11: STOP returns to idle and frees the line
  a_r11_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    (stopDet && !startDet) |=> (state == ST_IDLE && !ackLow && !txActive));
endmodule

// File: rtl/i2cRegDatapath.sv
module i2cRegDatapath
  import i2cRegPkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int PTR_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic             sdaS,
  input  logic             appWrEn,
  input  logic [PTR_W-1:0] appWrAddr,
  input  logic [7:0]       appWrData,
  input  logic [PTR_W-1:0] appRdAddr,
  output logic [7:0]       appRdData,
  output logic [7:0]       rxByte,
  output logic             txBit
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  logic [7:0] bank [NUM_REGS];
  logic [PTR_W-1:0] ptr, ptrNext;
  logic [7:0] txSh;

  assign ptrNext = (ptr == LAST) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr    <= '0;
      rxByte <= '0;
      txSh   <= 8'hFF;
    end else begin
      if (strobe.shiftIn) rxByte <= {rxByte[6:0], sdaS};
      if (strobe.loadPtr) ptr <= rxByte[PTR_W-1:0];
      if (strobe.wrReg) ptr <= ptrNext;
      if (strobe.loadTx) begin
        txSh <= bank[ptr];
        ptr  <= ptrNext;
      end else if (strobe.shiftTx) begin
        txSh <= {txSh[6:0], 1'b1};
      end
    end
  end

  // one storage cell per register; bus write outranks the application port
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bank[i] <= '0;
      else if (strobe.wrReg && ptr == PTR_W'(i)) bank[i] <= rxByte;
      else if (appWrEn && appWrAddr == PTR_W'(i)) bank[i] <= appWrData;
    end
  end

  assign appRdData = bank[appRdAddr];
  assign txBit     = txSh[7];

  // R5: a bus data byte lands at the pointer it was aimed at
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrReg |=> (bank[$past(ptr)] == $past(rxByte)));
  // R6: stepping past the last register returns to register 0
  a_r6_ptr_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.wrReg || strobe.loadTx) && ptr == LAST) |=> (ptr == '0));
endmodule

// File: rtl/i2cRegBankSlave.sv
module i2cRegBankSlave
  import i2cRegPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h51,
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2,
  localparam int        PTR_W       = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaPullLow,
  input  logic             appWrEn,
  input  logic [PTR_W-1:0] appWrAddr,
  input  logic [7:0]       appWrData,
  input  logic [PTR_W-1:0] appRdAddr,
  output logic [7:0]       appRdData
);
  logic sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic ackLow, txActive, txBit;
  logic [7:0] rxByte;
  dpStrobe_t strobe;

  i2cLineSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rstN, .sclIn, .sdaIn, .sclS, .sdaS,
    .sclRise, .sclFall, .startDet, .stopDet
  );

  i2cSlaveCtrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk, .rstN, .sclRise, .sclFall, .startDet, .stopDet,
    .sdaS, .rxByte, .strobe, .ackLow, .txActive
  );

  i2cRegDatapath #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk, .rstN, .strobe, .sdaS, .appWrEn, .appWrAddr, .appWrData,
    .appRdAddr, .appRdData, .rxByte, .txBit
  );

  assign sdaPullLow = ackLow || (txActive && !txBit);

  // R10: the data line drive is frozen while SCL stays high
  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS)) |-> $stable(sdaPullLow));
endmodule

// File: tb/sim_i2cRegBankSlave.sv
`timescale 1ns/1ps
module sim_i2cRegBankSlave;
  localparam int Q = 20;

  logic clk = 1'b0, rstN = 1'b0, sclM = 1'b1, sdaM = 1'b1;
  logic sdaLine, sdaPullLow;
  logic appWrEn = 1'b0;
  logic [3:0] appWrAddr = '0, appRdAddr = '0;
  logic [7:0] appWrData = '0, appRdData;
  int nChecks = 0, nFail = 0, r10Viol = 0;
  logic [7:0] expQ[$], obsQ[$];
  string tagQ[$];

  always #5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaPullLow;

  i2cRegBankSlave u0 (
    .clk, .rstN, .sclIn(sclM), .sdaIn(sdaLine), .sdaPullLow,
    .appWrEn, .appWrAddr, .appWrData, .appRdAddr, .appRdData
  );

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: compares read bytes as they arrive
  initial forever begin
    @(negedge clk);
    while (obsQ.size() > 0 && expQ.size() > 0) begin
      logic [7:0] o, e;
      string t;
      o = obsQ.pop_front();
      e = expQ.pop_front();
      t = tagQ.pop_front();
      chk(t, o, e);
    end
  end

  // R10 watcher: drive must not move while SCL is held high
  logic sclPrevM = 1'b1, drvPrev = 1'b0;
  always @(negedge clk) begin
    if (rstN && sclM && sclPrevM && sdaPullLow != drvPrev) r10Viol++;
    sclPrevM <= sclM;
    drvPrev  <= sdaPullLow;
  end

  task automatic busStart;
    w(Q); sdaM = 1'b1; w(Q); sclM = 1'b1; w(Q); sdaM = 1'b0; w(Q); sclM = 1'b0;
  endtask

  task automatic busStop;
    w(Q); sdaM = 1'b0; w(Q); sclM = 1'b1; w(Q); sdaM = 1'b1; w(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    logic s1, s2, s3;
    for (int i = 7; i >= 0; i--) begin
      w(Q); sdaM = b[i]; w(Q); sclM = 1'b1; w(2*Q); sclM = 1'b0;
    end
    w(Q); sdaM = 1'b1; w(Q); sclM = 1'b1;
    w(2);     s1 = sdaLine;
    w(Q-2);   s2 = sdaLine;
    w(Q-3);   s3 = sdaLine;
    w(1);     sclM = 1'b0;
    acked = !s1 && !s2 && !s3;
  endtask

  task automatic readByte(input logic giveAck, output logic slotHigh);
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; w(2*Q); sclM = 1'b1; w(Q); b[i] = sdaLine; w(Q); sclM = 1'b0;
    end
    w(Q); sdaM = !giveAck; w(Q); sclM = 1'b1; w(Q); slotHigh = sdaLine; w(Q); sclM = 1'b0;
    obsQ.push_back(b);
  endtask

  task automatic expectRd(logic [7:0] v, string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  task automatic appPeek(int idx, int exp, string req);
    appRdAddr = 4'(idx); w(1); chk(req, appRdData, exp);
  endtask

  task automatic appPoke(int idx, logic [7:0] v);
    appWrAddr = 4'(idx); appWrData = v; appWrEn = 1'b1; w(1); appWrEn = 1'b0;
  endtask

  task automatic runAll;
    logic a, hi;
    w(4); rstN = 1'b1; w(4);
    // R1 reset state
    chk("R1 sda released", sdaPullLow, 0);
    appPeek(0, 8'h00, "R1 reg0 cleared");
    appPeek(15, 8'h00, "R1 reg15 cleared");

    // R1/R7 direct read from the reset pointer, then R9 NACK release
    busStart; sendByte(8'hA3, a); chk("R2 ack read addr", a, 1);
    expectRd(8'h00, "R1 pointer starts at 0");
    readByte(1'b0, hi); chk("R9 nack slot high", hi, 1);
    w(2*Q); chk("R9 released after nack", sdaPullLow, 0);
    busStop;

    // R4/R5 pointer byte with upper nibble set, then data
    busStart; sendByte(8'hA2, a); chk("R2 ack write addr", a, 1);
    sendByte(8'h35, a); chk("R4 ack pointer byte", a, 1);
    sendByte(8'h11, a); chk("R5 ack data", a, 1);
    sendByte(8'h22, a); chk("R5 ack data", a, 1);
    sendByte(8'h33, a); chk("R5 ack data", a, 1);
    busStop; w(4);
    chk("R11 idle after stop", sdaPullLow, 0);
    appPeek(5, 8'h11, "R4 low nibble pointer");
    appPeek(6, 8'h22, "R5 increment");
    appPeek(7, 8'h33, "R12 app sees bus write");

    // R6 write across the wrap
    busStart; sendByte(8'hA2, a); sendByte(8'h0E, a);
    sendByte(8'hAA, a); sendByte(8'hBB, a); sendByte(8'hCC, a);
    busStop; w(4);
    appPeek(14, 8'hAA, "R6 reg14");
    appPeek(15, 8'hBB, "R6 reg15");
    appPeek(0, 8'hCC, "R6 wrapped to reg0");

    // R8 repeated start read after pointer write
    busStart; sendByte(8'hA2, a); sendByte(8'h05, a);
    busStart; sendByte(8'hA3, a); chk("R8 ack after repeated start", a, 1);
    expectRd(8'h11, "R8 first byte"); readByte(1'b1, hi);
    expectRd(8'h22, "R9 ack gives next"); readByte(1'b1, hi);
    expectRd(8'h33, "R9 third byte"); readByte(1'b0, hi);
    busStop;

    // R7/R12 direct read continues at pointer 8
    appPoke(8, 8'h5A); appPoke(9, 8'h6B); appPoke(10, 8'h4D);
    busStart; sendByte(8'hA3, a);
    expectRd(8'h5A, "R7 current pointer"); readByte(1'b1, hi);
    expectRd(8'h6B, "R12 bus sees app write"); readByte(1'b0, hi);
    busStop;

    // R3 foreign address: no ack, nothing changes
    busStart; sendByte(8'hA4, a); chk("R3 no ack foreign addr", a, 0);
    sendByte(8'h02, a); chk("R3 no ack after foreign", a, 0);
    sendByte(8'h99, a); chk("R3 no ack after foreign", a, 0);
    busStop; w(4);
    appPeek(2, 8'h00, "R3 reg2 untouched");
    busStart; sendByte(8'hA3, a);
    expectRd(8'h4D, "R3 pointer untouched"); readByte(1'b0, hi);
    busStop;

    // R6 read across the wrap
    busStart; sendByte(8'hA2, a); sendByte(8'h0F, a);
    busStart; sendByte(8'hA3, a);
    expectRd(8'hBB, "R6 read reg15"); readByte(1'b1, hi);
    expectRd(8'hCC, "R6 read wraps to reg0"); readByte(1'b1, hi);
    expectRd(8'h00, "R6 read reg1"); readByte(1'b0, hi);
    busStop; w(4);
    chk("R11 idle after stop", sdaPullLow, 0);

    w(50);
    chk("R10 drive stable while SCL high", r10Viol, 0);
    chk("R7 scoreboard drained", expQ.size(), 0);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        nChecks++; nFail++;
        $display("FAIL watchdog (all requirements) act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule